// File: doc/BRIEF.md
# Postfix Stack Arithmetic Engine

This block evaluates arithmetic written in postfix order. It takes a stream of 16-bit instruction words. Each word either moves a value between a word-addressed data memory and an internal last-in-first-out operand stack, or combines the two topmost stack entries. Add, subtract and multiply name no operands. They always read the two most recent entries and leave their result on the stack. The engine can therefore reduce an expression such as `(a+b)-(c-d)` to one value and store it back to memory.

Instructions enter on a valid/ready handshake. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low while that instruction executes, so the producer must hold its word until the handshake completes. An instruction that stops the engine keeps `in_ready` low until reset.

Status pins show the top entry, the entry count, busy, halted and a sticky error flag. A test port, usable whenever the engine is not executing, lets a host preload and inspect the data memory.

Top module: `rpn_engine`

## Requirements
- R1: After reset, `depth` is 0, `tos` is 0, `error` and `halted` are low, `busy` is low and `in_ready` is high.
- R2: A word is accepted on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is low for exactly one following cycle for every instruction except a successful PUSH, which keeps it low for two cycles. `busy` is high in exactly those cycles.
- R3: The opcode is in bits [15:12] and the address in bits [11:0]. The codes are PUSH=1, POP=2, ADD=3, SUB=4, MUL=5 and HALT=15. The address bits have no effect on ADD, SUB, MUL or HALT.
- R4: PUSH X reads memory word X and places it on top of the stack, so `depth` rises by one and `tos` shows the word.
- R5: POP X writes the top entry to memory word X and removes it, so `depth` falls by one.
- R6: ADD replaces the two top entries with their sum modulo 2^16, so `depth` falls by one.
- R7: SUB replaces the two top entries with next-to-top minus top, modulo 2^16.
- R8: MUL replaces the two top entries with the low 16 bits of their product.
- R9: A PUSH while 16 entries are held raises `error` and leaves the stack unchanged.
- R10: A POP on an empty stack, or an ADD, SUB or MUL with fewer than two entries, raises `error` and leaves both the stack and the memory unchanged.
- R11: An undefined opcode raises `error` and changes nothing else. `error` stays high until reset, and later legal instructions still execute.
- R12: After HALT, `halted` is high and `in_ready` stays low until reset, whatever `in_valid` does.
- R13: While the engine is not executing, `tp_en` with `tp_we` high writes `tp_wdata` to word `tp_addr`. `tp_en` with `tp_we` low presents that word on `tp_rdata` one cycle later.
- R14: Running PUSH a, PUSH b, ADD, PUSH c, PUSH d, SUB, SUB, POP z leaves (a+b)-(c-d) in word z and `depth` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Engine can take an instruction this cycle |
| in_instr | input | 16 | Instruction word: opcode [15:12], address [11:0] |
| tos | output | 16 | Top stack entry, 0 when the stack is empty |
| depth | output | 5 | Number of stack entries, 0 to 16 |
| busy | output | 1 | An accepted instruction is executing |
| halted | output | 1 | Engine stopped by HALT |
| error | output | 1 | Sticky fault flag |
| tp_en | input | 1 | Test port access strobe |
| tp_we | input | 1 | Test port write select |
| tp_addr | input | 12 | Test port word address |
| tp_wdata | input | 16 | Test port write data |
| tp_rdata | output | 16 | Registered memory read data |

## Verification
The bench targets operand order. A subtract that takes top minus next-to-top returns the negated value, which shows up both in a direct SUB and in the full expression. It drives the stack to both ends: a PUSH on a full stack that still writes would move `depth` to an impossible value, and an underflowing POP that still writes memory would overwrite a preloaded word the bench reads back. It also checks results that wrap, the length of each handshake stall, the effect of junk address bits on no-operand words, whether the error flag stays set, and the permanent stall after HALT. A design off by one on the registered read would push stale data or release `in_ready` a cycle early.

// File: rtl/rpn_pkg.sv
package rpn_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_PUSH = 4'd1,
    OPC_POP  = 4'd2,
    OPC_ADD  = 4'd3,
    OPC_SUB  = 4'd4,
    OPC_MUL  = 4'd5,
    OPC_HALT = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_FILL,
    ST_STOP
  } eng_state_e;
endpackage

// File: rtl/rpn_stack.sv
module rpn_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          replace,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top,
  output logic [W-1:0]  next,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  slots [DEPTH];
  logic [IW-1:0] top_idx, nxt_idx, free_idx;

  assign free_idx = IW'(count);
  assign top_idx  = IW'(count - CW'(1));
  assign nxt_idx  = IW'(count - CW'(2));
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign top      = empty ? '0 : slots[top_idx];
  assign next     = (count < CW'(2)) ? '0 : slots[nxt_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_here;
    assign wr_here = (push && free_idx == IW'(i)) || (replace && nxt_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slots[i] <= '0;
      else if (wr_here) slots[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (push)             count <= count + CW'(1);
    else if (pop || replace)   count <= count - CW'(1);
  end

  // R9
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R10
  pop_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop |-> !empty) and (replace |-> count >= CW'(2)));
  // R10
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({push, pop, replace}));
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH));
endmodule

// File: rtl/rpn_alu.sv
module rpn_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   opc,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  import rpn_pkg::*;
  logic [2*W-1:0] prod;

  assign prod = {{W{1'b0}}, lhs} * {{W{1'b0}}, rhs};

  always_comb begin
    case (opc)
      OPC_ADD: res = lhs + rhs;
      OPC_SUB: res = lhs - rhs;
      OPC_MUL: res = prod[W-1:0];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rpn_dmem.sv
module rpn_dmem #(
  parameter int W    = 16,
  parameter int AW   = 12,
  localparam int NWORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [NWORDS];

  always_ff @(posedge clk) begin
    if (en && we) cells[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (en && !we)  rdata <= cells[addr];
  end
endmodule

// File: rtl/rpn_engine.sv
module rpn_engine
  import rpn_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int STACK_DEPTH = 16,
  localparam int CW         = $clog2(STACK_DEPTH + 1),
  localparam int INSTR_W    = OPC_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  output logic [DATA_W-1:0]  tos,
  output logic [CW-1:0]      depth,
  output logic               busy,
  output logic               halted,
  output logic               error,
  input  logic               tp_en,
  input  logic               tp_we,
  input  logic [ADDR_W-1:0]  tp_addr,
  input  logic [DATA_W-1:0]  tp_wdata,
  output logic [DATA_W-1:0]  tp_rdata
);
  eng_state_e         state;
  logic [INSTR_W-1:0] instr_q;
  logic               err_q;

  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] oaddr;
  logic is_push, is_pop, is_bin, is_halt, is_bad;
  logic push_ok, pop_ok, bin_ok, raise_err, in_exec;

  logic [DATA_W-1:0] st_top, st_next, st_wdata, alu_res, mem_rdata;
  logic [CW-1:0]     st_count;
  logic st_full, st_empty, st_push, st_pop, st_rep;

  logic              mem_en, mem_we, eng_owns;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  assign opc     = instr_q[INSTR_W-1 -: OPC_W];
  assign oaddr   = instr_q[ADDR_W-1:0];
  assign in_exec = (state == ST_EXEC);

  assign is_push = (opc == OPC_PUSH);
  assign is_pop  = (opc == OPC_POP);
  assign is_bin  = (opc == OPC_ADD) || (opc == OPC_SUB) || (opc == OPC_MUL);
  assign is_halt = (opc == OPC_HALT);
  assign is_bad  = !(is_push || is_pop || is_bin || is_halt);

  assign push_ok   = is_push && !st_full;
  assign pop_ok    = is_pop && !st_empty;
  assign bin_ok    = is_bin && (st_count >= CW'(2));
  assign raise_err = in_exec && ((is_push && st_full) || (is_pop && st_empty) ||
                                 (is_bin && !bin_ok) || is_bad);

  // Memory port: engine owns it while an instruction runs, test port otherwise.
  assign eng_owns  = (state == ST_EXEC) || (state == ST_FILL);
  assign mem_en    = eng_owns ? (in_exec && (push_ok || pop_ok)) : tp_en;
  assign mem_we    = eng_owns ? pop_ok : tp_we;
  assign mem_addr  = eng_owns ? oaddr : tp_addr;
  assign mem_wdata = eng_owns ? st_top : tp_wdata;

  assign st_push  = (state == ST_FILL);
  assign st_pop   = in_exec && pop_ok;
  assign st_rep   = in_exec && bin_ok;
  assign st_wdata = st_push ? mem_rdata : alu_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      instr_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (raise_err) err_q <= 1'b1;
      case (state)
        ST_IDLE: if (in_valid) begin
          instr_q <= in_instr;
          state   <= ST_EXEC;
        end
        ST_EXEC: begin
          if (push_ok)      state <= ST_FILL;
          else if (is_halt) state <= ST_STOP;
          else              state <= ST_IDLE;
        end
        ST_FILL: state <= ST_IDLE;
        default: state <= ST_STOP;
      endcase
    end
  end

  rpn_stack #(.W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(st_push), .pop(st_pop), .replace(st_rep),
    .wdata(st_wdata), .top(st_top), .next(st_next), .count(st_count),
    .full(st_full), .empty(st_empty)
  );

  rpn_alu #(.W(DATA_W)) u_alu (
    .opc(opc), .lhs(st_next), .rhs(st_top), .res(alu_res)
  );

  rpn_dmem #(.W(DATA_W), .AW(ADDR_W)) u_dmem (
    .clk(clk), .rst_n(rst_n), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  assign in_ready = (state == ST_IDLE);
  assign busy     = eng_owns;
  assign halted   = (state == ST_STOP);
  assign error    = err_q;
  assign tos      = st_top;
  assign depth    = st_count;
  assign tp_rdata = mem_rdata;

  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) error |=> error);
  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !in_ready));
  // R10
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_err |=> $stable(depth));
  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && in_ready));
endmodule

// File: tb/rpn_engine_bench.sv
module rpn_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = '0;
  logic [15:0] tos;
  logic [4:0]  depth;
  logic        busy, halted, error;
  logic        tp_en = 1'b0, tp_we = 1'b0;
  logic [11:0] tp_addr = '0;
  logic [15:0] tp_wdata = '0;
  logic [15:0] tp_rdata;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rpn_engine u_rpn_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .tos(tos), .depth(depth), .busy(busy),
    .halted(halted), .error(error), .tp_en(tp_en), .tp_we(tp_we),
    .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; tp_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] ins);
    for (int g = 0; g < 50 && !in_ready; g++) @(negedge clk);
    in_valid = 1'b1; in_instr = ins;
    @(negedge clk);
    in_valid = 1'b0; in_instr = 16'hA5A5;
    for (int g = 0; g < 50 && !in_ready && !halted; g++) @(negedge clk);
  endtask

  task automatic stall_len(input logic [15:0] ins, output int n);
    n = 0;
    in_valid = 1'b1; in_instr = ins;
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready && n < 50) begin
      if (!busy) n = n + 100;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic tp_write(input logic [11:0] a, input logic [15:0] d);
    tp_en = 1'b1; tp_we = 1'b1; tp_addr = a; tp_wdata = d;
    @(negedge clk);
    tp_en = 1'b0; tp_we = 1'b0;
  endtask

  task automatic tp_read(input logic [11:0] a, output logic [15:0] d);
    tp_en = 1'b1; tp_we = 1'b0; tp_addr = a;
    @(negedge clk);
    tp_en = 1'b0;
    d = tp_rdata;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 depth", 32'(depth), 0);
    check("R1 tos", 32'(tos), 0);
    check("R1 flags", {29'd0, error, halted, busy}, 0);
    check("R1 ready", 32'(in_ready), 1);
  endtask

  task automatic t_push_pop();
    logic [15:0] d;
    int n;
    tp_write(12'd10, 16'h1234);
    tp_read(12'd10, d);
    check("R13 tp readback", 32'(d), 32'h1234);
    stall_len(16'h100A, n);
    check("R2 push stall", n, 2);
    check("R4 tos", 32'(tos), 32'h1234);
    check("R4 depth", 32'(depth), 1);
    stall_len(16'h2014, n);
    check("R2 pop stall", n, 1);
    check("R5 depth", 32'(depth), 0);
    tp_read(12'd20, d);
    check("R5 mem", 32'(d), 32'h1234);
  endtask

  task automatic t_arith();
    int n;
    tp_write(12'd30, 16'hFFFF); tp_write(12'd31, 16'h0002);
    tp_write(12'd32, 16'h0003); tp_write(12'd33, 16'h000A);
    tp_write(12'd34, 16'h1234); tp_write(12'd35, 16'h0010);
    send(16'h101E); send(16'h101F);
    stall_len(16'h3ABC, n);
    check("R2 add stall", n, 1);
    check("R6 R3 add wrap ignores addr", 32'(tos), 32'h0001);
    check("R6 depth", 32'(depth), 1);
    send(16'h1020); send(16'h1021); send(16'h4000);
    check("R7 sub order", 32'(tos), 32'hFFF9);
    check("R7 depth", 32'(depth), 2);
    send(16'h1022); send(16'h1023); send(16'h5FFF);
    check("R8 mul low", 32'(tos), 32'h2340);
    check("R8 depth", 32'(depth), 3);
    check("R11 no error", 32'(error), 0);
  endtask

  task automatic t_expr();
    logic [15:0] d;
    do_reset();
    tp_write(12'd100, 16'd9); tp_write(12'd101, 16'd4);
    tp_write(12'd102, 16'd20); tp_write(12'd103, 16'd6);
    send(16'h1064); send(16'h1065); send(16'h3000);
    send(16'h1066); send(16'h1067); send(16'h4000); send(16'h4000);
    send(16'h20C8);
    tp_read(12'd200, d);
    check("R14 result", 32'(d), 32'hFFFF);
    check("R14 depth", 32'(depth), 0);
  endtask

  task automatic t_underflow();
    logic [15:0] d;
    do_reset();
    tp_write(12'd300, 16'h5555);
    send(16'h212C);
    check("R10 pop empty err", 32'(error), 1);
    check("R10 pop empty depth", 32'(depth), 0);
    tp_read(12'd300, d);
    check("R10 mem untouched", 32'(d), 32'h5555);
    do_reset();
    send(16'h112C);
    send(16'h3000);
    check("R10 add one entry err", 32'(error), 1);
    check("R10 add keeps stack", {11'd0, depth, tos}, {11'd0, 5'd1, 16'h5555});
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 16; i++) tp_write(12'(400 + i), 16'(i + 1));
    tp_write(12'd420, 16'hBEEF);
    for (int i = 0; i < 16; i++) send({4'h1, 12'(400 + i)});
    check("R9 full depth", 32'(depth), 16);
    check("R9 no err yet", 32'(error), 0);
    send(16'h11A4);
    check("R9 overflow err", 32'(error), 1);
    check("R9 stack kept", {11'd0, depth, tos}, {11'd0, 5'd16, 16'd16});
  endtask

  task automatic t_undef();
    do_reset();
    tp_write(12'd500, 16'h0042);
    send(16'h7123);
    check("R11 undef err", 32'(error), 1);
    check("R11 undef depth", 32'(depth), 0);
    send(16'h11F4);
    check("R11 later push works", 32'(tos), 32'h0042);
    check("R11 sticky", 32'(error), 1);
  endtask

  task automatic t_halt();
    do_reset();
    tp_write(12'd600, 16'h0077);
    send(16'h1258);
    send(16'hF123);
    check("R12 halted", 32'(halted), 1);
    in_valid = 1'b1; in_instr = 16'h1258;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R12 ready low", 32'(in_ready), 0);
    end
    in_valid = 1'b0;
    check("R12 depth kept", 32'(depth), 1);
    check("R12 still halted", 32'(halted), 1);
    do_reset();
    check("R12 reset clears", {30'd0, halted, in_ready}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_arith();
    t_expr();
    t_underflow();
    t_overflow();
    t_undef();
    t_halt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule